// File: doc/BRIEF.md
# Interprocessor Event Message Unit

Each core carries one of these units to exchange short asynchronous events with other cores without going through shared memory. On the sending side the local CPU fills four store slots: destination core, event code, first data word and second data word. The store to the last slot launches the event. The unit then puts out a four-word stream toward the core's interface unit. The first word of that stream is a header whose class tag marks it as event traffic rather than memory traffic. No answer ever comes back for a sent event.

On the receiving side the unit takes in three-word event streams from the interconnect: event code, parameter 1, parameter 2. It queues the complete events and keeps an interrupt request raised for as long as any event is pending. While the request is high, the oldest event is shown on the event outputs. A one-cycle acknowledge from the CPU removes that event. Both stream interfaces use valid/ready: a word moves only on a clock edge where valid and ready are both high. A sender that has raised valid must hold it and the word until the transfer takes place.

Top module: `evt_msg_unit`

## Requirements
- R1: After reset, tx_valid and irq are low, and st_ready and rx_ready are high.
- R2: A store to slot 0 (destination), slot 1 (event code) or slot 2 (data 1) only loads that slot and starts no transmission: tx_valid stays low.
- R3: A store accepted on slot 3 (data 2) raises tx_valid in the next cycle. The unit then sends exactly four words in this order: header, event code, data 1, data 2. tx_last is high only on the fourth word.
- R4: In the header word, bits 31:30 hold the event class tag 2'b10, bits 3:0 hold the destination core (the low four bits stored to slot 0), and all other bits are zero.
- R5: While tx_valid is high and tx_ready is low, tx_valid stays high and tx_data stays unchanged in the next cycle.
- R6: From the cycle after the launching store until the cycle after the fourth word is accepted, st_ready is low. A store offered in that window, including one to slot 0, waits and does not change the event being sent. It is taken once the send ends.
- R7: Three accepted receive words form one event (event code, parameter 1, parameter 2), and irq is high in the cycle after the third word is accepted.
- R8: While irq is high, evt_code, evt_p1 and evt_p2 show the oldest pending event. Each cycle with irq_ack high removes exactly one event. Events leave in the order they arrived, and irq falls once none are left.
- R9: Up to 4 complete events are held. While 4 are pending, rx_ready is low and an offered word is not taken. The word is taken and the event is delivered intact once an acknowledge frees a place.
- R10: irq_ack while irq is low has no effect: irq stays low, and the next event received is presented correctly and is removed by a single acknowledge.
- R11: Receiving and acknowledging events produces no output stream: tx_valid stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | CPU store request |
| st_ready | output | 1 | Store accepted on this edge when high |
| st_addr | input | 2 | Store slot: 0 destination, 1 code, 2 data 1, 3 data 2 and launch |
| st_data | input | 32 | Store data |
| tx_valid | output | 1 | Outgoing event word valid |
| tx_ready | input | 1 | Interface unit can take the outgoing word |
| tx_data | output | 32 | Outgoing event word |
| tx_last | output | 1 | Marks the fourth (final) outgoing word |
| rx_valid | input | 1 | Incoming event word valid |
| rx_ready | output | 1 | Unit can take an incoming word |
| rx_data | input | 32 | Incoming event word |
| irq | output | 1 | Interrupt request, high while events are pending |
| irq_ack | input | 1 | Interrupt acknowledge, pops one event per cycle high |
| evt_code | output | 32 | Event code of the oldest pending event |
| evt_p1 | output | 32 | Parameter 1 of the oldest pending event |
| evt_p2 | output | 32 | Parameter 2 of the oldest pending event |

## Verification
A wrong word index in the sender shows up on the very next accepted transfer: the wrong word appears, tx_last lands on the wrong beat, or st_ready comes back early or late. A receive word counter that is out of step shifts every later event by one field. This appears at the next interrupt as parameters in the wrong outputs. A queue count that is off shows at once in irq or rx_ready at the queue boundaries: an empty queue still requesting an interrupt, a fifth event taken, or an acknowledge that removes nothing or removes two.

// File: rtl/evt_msg_pkg.sv
package evt_msg_pkg;
  // Position of each CPU-visible store slot; slot 3 launches the send.
  typedef enum logic [1:0] {
    SLOT_DEST = 2'd0,
    SLOT_CODE = 2'd1,
    SLOT_DAT1 = 2'd2,
    SLOT_DAT2 = 2'd3
  } slot_e;

  // Class tag in the top two header bits; the interface unit routes on it.
  localparam logic [1:0] EVT_CLASS_TAG = 2'b10;
  localparam int unsigned TX_BEATS = 4;
  localparam int unsigned RX_BEATS = 3;
endpackage

// File: rtl/evt_tx.sv
module evt_tx
  import evt_msg_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CORE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [1:0]        st_addr,
  input  logic [DATA_W-1:0] st_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_last
);
  localparam int unsigned BEAT_W = $clog2(TX_BEATS);
  localparam int unsigned NSLOT  = TX_BEATS - 1;

  logic [CORE_W-1:0] dest_q;
  logic [DATA_W-1:0] slot_q [NSLOT];
  logic              busy_q;
  logic [BEAT_W-1:0] beat_q;
  logic              st_take;
  logic              beat_go;
  logic [DATA_W-1:0] hdr;

  assign st_ready = !busy_q;
  assign st_take  = st_valid && st_ready;
  assign beat_go  = tx_valid && tx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dest_q <= '0;
    else if (st_take && st_addr == SLOT_DEST) dest_q <= st_data[CORE_W-1:0];
  end

  // One holding register per payload slot; slot g+1 maps to register g.
  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q[g] <= '0;
      else if (st_take && st_addr == 2'(g + 1)) slot_q[g] <= st_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      beat_q <= '0;
    end else if (!busy_q) begin
      if (st_take && st_addr == SLOT_DAT2) begin
        busy_q <= 1'b1;
        beat_q <= '0;
      end
    end else if (beat_go) begin
      if (tx_last) begin
        busy_q <= 1'b0;
        beat_q <= '0;
      end else begin
        beat_q <= beat_q + 1'b1;
      end
    end
  end

  always_comb begin
    hdr = '0;
    hdr[DATA_W-1 -: 2] = EVT_CLASS_TAG;
    hdr[CORE_W-1:0]    = dest_q;
  end

  always_comb begin
    if (beat_q == '0) tx_data = hdr;
    else              tx_data = slot_q[beat_q - 1'b1];
  end

  assign tx_valid = busy_q;
  assign tx_last  = busy_q && (beat_q == BEAT_W'(TX_BEATS - 1));

  a_r3_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_ready && st_addr == SLOT_DAT2) |=> (tx_valid && !tx_last));
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  a_r6_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !(tx_ready && tx_last)) |=> !st_ready);
  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_last) |=> (st_ready && !tx_valid));
endmodule

// File: rtl/evt_rx_asm.sv
module evt_rx_asm
  import evt_msg_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rx_valid,
  output logic                     rx_ready,
  input  logic [DATA_W-1:0]        rx_data,
  input  logic                     room,
  output logic                     push,
  output logic [3*DATA_W-1:0]      push_data
);
  localparam int unsigned CNT_W = $clog2(RX_BEATS);

  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] code_q;
  logic [DATA_W-1:0] p1_q;
  logic              take;

  assign rx_ready = room;
  assign take     = rx_valid && rx_ready;
  assign push     = take && (cnt_q == CNT_W'(RX_BEATS - 1));
  assign push_data = {code_q, p1_q, rx_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      code_q <= '0;
      p1_q   <= '0;
    end else if (take) begin
      if (cnt_q == '0) code_q <= rx_data;
      if (cnt_q == CNT_W'(1)) p1_q <= rx_data;
      if (cnt_q == CNT_W'(RX_BEATS - 1)) cnt_q <= '0;
      else cnt_q <= cnt_q + 1'b1;
    end
  end

  a_r7_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(RX_BEATS));
  a_r9_hold_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (!room) |=> $stable(cnt_q));
endmodule

// File: rtl/evt_fifo.sv
module evt_fifo #(
  parameter int unsigned WIDTH = 96,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_q;
  logic [PTR_W-1:0] rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_pop;
  logic             do_push;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign do_pop  = pop && !empty;
  assign do_push = push && !full;
  assign dout    = mem[rd_q];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  a_r7_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> !empty);
  a_r8_drain_last: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_W'(1) && pop && !push) |=> empty);
  a_r10_idle_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> empty);
endmodule

// File: rtl/evt_msg_unit.sv
module evt_msg_unit
  import evt_msg_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CORE_W = 4,
  parameter int unsigned DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [1:0]        st_addr,
  input  logic [DATA_W-1:0] st_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_last,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  output logic              irq,
  input  logic              irq_ack,
  output logic [DATA_W-1:0] evt_code,
  output logic [DATA_W-1:0] evt_p1,
  output logic [DATA_W-1:0] evt_p2
);
  localparam int unsigned EVT_W = RX_BEATS * DATA_W;

  logic             q_push;
  logic [EVT_W-1:0] q_din;
  logic [EVT_W-1:0] q_dout;
  logic             q_empty;
  logic             q_full;

  evt_tx #(.DATA_W(DATA_W), .CORE_W(CORE_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .st_valid (st_valid),
    .st_ready (st_ready),
    .st_addr  (st_addr),
    .st_data  (st_data),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_data  (tx_data),
    .tx_last  (tx_last)
  );

  evt_rx_asm #(.DATA_W(DATA_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .rx_ready  (rx_ready),
    .rx_data   (rx_data),
    .room      (!q_full),
    .push      (q_push),
    .push_data (q_din)
  );

  evt_fifo #(.WIDTH(EVT_W), .DEPTH(DEPTH)) u_q (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (q_push),
    .din   (q_din),
    .pop   (irq_ack),
    .dout  (q_dout),
    .empty (q_empty),
    .full  (q_full)
  );

  assign irq      = !q_empty;
  assign evt_code = q_dout[EVT_W-1 -: DATA_W];
  assign evt_p1   = q_dout[DATA_W +: DATA_W];
  assign evt_p2   = q_dout[DATA_W-1:0];

  a_r7_irq_after_push: assert property (@(posedge clk) disable iff (!rst_n)
    (q_push && !irq_ack) |=> irq);
  a_r8_stable_head: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack) |=> (irq && $stable(evt_code) && $stable(evt_p1) && $stable(evt_p2)));
endmodule

// File: tb/test_evt_msg_unit.sv
module test_evt_msg_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        st_valid = 1'b0;
  logic        st_ready;
  logic [1:0]  st_addr = '0;
  logic [31:0] st_data = '0;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [31:0] tx_data;
  logic        tx_last;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [31:0] rx_data = '0;
  logic        irq;
  logic        irq_ack = 1'b0;
  logic [31:0] evt_code, evt_p1, evt_p2;

  always #5 clk = ~clk;

  evt_msg_unit i_evt_msg_unit (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .irq(irq), .irq_ack(irq_ack),
    .evt_code(evt_code), .evt_p1(evt_p1), .evt_p2(evt_p2)
  );

  int total = 0;
  int bad = 0;
  logic [31:0] got [4];
  logic        got_last [4];

  // Rows: destination, event code, data 1, data 2.
  localparam logic [31:0] VEC [4][4] = '{
    '{32'h3, 32'h0000_00A5, 32'h1111_0001, 32'h2222_0002},
    '{32'hF, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000},
    '{32'h0, 32'hDEAD_BEEF, 32'h8000_0000, 32'h7FFF_FFFF},
    '{32'h9, 32'h0000_0042, 32'h1234_5678, 32'h9ABC_DEF0}
  };
  // Per-cycle tx_ready pattern used while each row is sent.
  localparam logic [7:0] RDY [4] = '{8'hFF, 8'b1010_1010, 8'b0001_0001, 8'b1100_1100};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] hdr_of(input logic [31:0] d);
    return 32'h8000_0000 | (d & 32'h0000_000F);
  endfunction

  task automatic do_store(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    st_valid = 1'b1; st_addr = a; st_data = d;
    while (!st_ready) @(negedge clk);
    @(negedge clk);
    st_valid = 1'b0;
  endtask

  task automatic collect(input logic [7:0] pat);
    int n = 0;
    int cyc = 0;
    logic stalled = 1'b0;
    logic [31:0] held = '0;
    while (n < 4 && cyc < 200) begin
      @(negedge clk);
      if (stalled) begin
        chk("R5 valid held", tx_valid, 1);
        chk("R5 data held", tx_data, held);
      end
      tx_ready = pat[cyc % 8];
      stalled = 1'b0;
      if (tx_valid && tx_ready) begin
        got[n] = tx_data; got_last[n] = tx_last; n++;
      end else if (tx_valid) begin
        stalled = 1'b1; held = tx_data;
      end
      cyc++;
    end
    chk("R3 four words sent", n, 4);
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic send_rx(input logic [31:0] c, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] w [3];
    w[0] = c; w[1] = a; w[2] = b;
    for (int i = 0; i < 3; i++) begin
      rx_valid = 1'b1; rx_data = w[i];
      while (!rx_ready) @(negedge clk);
      @(negedge clk);
    end
    rx_valid = 1'b0;
  endtask

  task automatic ack_check(input string req, input logic [31:0] c, input logic [31:0] a,
                           input logic [31:0] b);
    chk({req, " irq"}, irq, 1);
    chk({req, " code"}, evt_code, c);
    chk({req, " p1"}, evt_p1, a);
    chk({req, " p2"}, evt_p2, b);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 tx_valid", tx_valid, 0);
    chk("R1 irq", irq, 0);
    chk("R1 st_ready", st_ready, 1);
    chk("R1 rx_ready", rx_ready, 1);

    // Table walk: send each row, then receive it back and acknowledge.
    for (int v = 0; v < 4; v++) begin
      do_store(2'd0, VEC[v][0]);
      do_store(2'd1, VEC[v][1]);
      do_store(2'd2, VEC[v][2]);
      chk("R2 no send before slot 3", tx_valid, 0);
      chk("R2 st_ready", st_ready, 1);
      do_store(2'd3, VEC[v][3]);
      chk("R3 tx_valid next cycle", tx_valid, 1);
      chk("R6 st_ready low", st_ready, 0);
      collect(RDY[v]);
      chk("R4 header", got[0], hdr_of(VEC[v][0]));
      chk("R3 code", got[1], VEC[v][1]);
      chk("R3 data1", got[2], VEC[v][2]);
      chk("R3 data2", got[3], VEC[v][3]);
      chk("R3 last flags", {31'b0, got_last[0], got_last[1], got_last[2], got_last[3]} >> 0,
          32'h0000_0001 | 32'h0);
      chk("R6 st_ready back", st_ready, 1);
      chk("R3 tx idle", tx_valid, 0);
      send_rx(VEC[v][1], VEC[v][2], VEC[v][3]);
      chk("R7 irq after event", irq, 1);
      chk("R11 no reply", tx_valid, 0);
      ack_check("R8", VEC[v][1], VEC[v][2], VEC[v][3]);
      chk("R8 irq low after pop", irq, 0);
      chk("R11 no reply after ack", tx_valid, 0);
    end

    // R10: acknowledge with nothing pending.
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    @(negedge clk);
    chk("R10 irq stays low", irq, 0);
    send_rx(32'h55, 32'h66, 32'h77);
    ack_check("R10", 32'h55, 32'h66, 32'h77);
    chk("R10 one ack empties", irq, 0);

    // R9: fill to four, offer a fifth while full, then free one place.
    for (int i = 0; i < 4; i++)
      send_rx(32'd100 + 32'(i), 32'h1100 + 32'(i), 32'h2200 + 32'(i));
    chk("R9 rx_ready low when full", rx_ready, 0);
    fork
      send_rx(32'd104, 32'h1104, 32'h2204);
      begin
        repeat (3) begin
          @(negedge clk);
          chk("R9 word held off", rx_ready, 0);
        end
        ack_check("R8 order", 32'd100, 32'h1100, 32'h2200);
      end
    join
    for (int i = 1; i < 5; i++)
      ack_check("R9 drain", 32'd100 + 32'(i), 32'h1100 + 32'(i), 32'h2200 + 32'(i));
    chk("R8 empty after drain", irq, 0);
    chk("R11 no reply after burst", tx_valid, 0);

    // R6: a slot 0 store during a send waits and leaves that send intact.
    do_store(2'd0, 32'h5);
    do_store(2'd1, 32'hC0DE);
    do_store(2'd2, 32'h1);
    do_store(2'd3, 32'h2);
    fork
      do_store(2'd0, 32'h7);
      collect(8'b0110_0110);
    join
    chk("R6 header kept old dest", got[0], hdr_of(32'h5));
    do_store(2'd1, 32'hC0DF);
    do_store(2'd2, 32'h3);
    do_store(2'd3, 32'h4);
    collect(8'hFF);
    chk("R6 stalled store took effect", got[0], hdr_of(32'h7));
    chk("R6 code after stall", got[1], 32'hC0DF);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule